// File: doc/BRIEF.md
# Interrupt Status and Enable Controller

This block gathers the interrupt sources of a network interface controller into one 32-bit status word, an enable word and a single interrupt line. Single-cycle pulses from the transmit and receive paths, a software trigger, a ready indication and a midpoint crossing of a 32-bit receive dropped-frame counter are latched as sticky bits. Software clears each sticky bit by writing 1 to its position. Pending levels from four sub-blocks (timestamp unit, switch fabric, two PHYs) appear as read-only bits. These can only be cleared at their own source.

Software reaches the block through a plain register port. A write is one cycle with `reg_wr` high, and it takes effect at that clock edge. A read is combinational from `reg_addr` to `reg_rdata`. Three words are mapped:

| Byte offset | Contents |
|---|---|
| 0x058 | Status |
| 0x05C | Enable |
| 0x054 | Control (bit 0 is the master gate) |

Status always shows every source, whether or not that source is enabled. The interrupt output is a registered level.

Top module: `nic_irq_ctrl`

## Requirements
- R1: After reset the status word, enable word, master gate and `irq_o` are all 0.
- R2: A one-cycle pulse sets a status bit at the next clock edge, and the bit holds until it is cleared. `evt_tx_halt` sets bit 25, `evt_rx_halt` sets bit 24, `evt_tx_ioc` sets bit 21 and `evt_rx_dma` sets bit 20.
- R3: A write to offset 0x058 clears each sticky bit (31, 30, 25, 24, 23, 21, 20) whose data bit is 1. Data bits that are 0 leave the status unchanged.
- R4: A set event and a write-1-to-clear of the same bit in the same cycle leave the bit set.
- R5: Status bits 29..26 always equal `src_pending[3:0]`, with bit 26 taken from `src_pending[0]`. Writes to offset 0x058 do not change them.
- R6: Bit 23 is set only when `drop_count` moves from 0x7FFFFFFF in one cycle to 0x80000000 in the next. No other step sets it, including the wrap from 0xFFFFFFFF to 0.
- R7: Bit 30 is set on a rising edge of `dev_ready`. While `dev_ready` stays high after a clear, the bit remains clear.
- R8: A write to offset 0x05C with data bit 31 high sets status bit 31. Writing 1 to bit 31 at 0x058 clears it.
- R9: Status bit 22 and bits 19..0 always read 0. The enable word stores only bits 31..23 and 21..20, and all other bits read 0.
- R10: A status bit is reported even when its enable bit is 0.
- R11: `irq_o` equals, one cycle later, the master gate (bit 0 of offset 0x054) ANDed with the OR of status ANDed with enable. It stays high until every enabled pending bit is cleared.
- R12: A read of any offset other than 0x054, 0x058 and 0x05C returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| evt_tx_halt | input | 1 | Pulse: transmitter halted after a stop request |
| evt_rx_halt | input | 1 | Pulse: receiver halted |
| evt_tx_ioc | input | 1 | Pulse: a buffer flagged for completion interrupt is fully loaded into the transmit FIFO |
| evt_rx_dma | input | 1 | Pulse: the programmed receive DMA amount has been drained |
| drop_count | input | 32 | Current value of the receive dropped-frame counter |
| dev_ready | input | 1 | Level: device accessible |
| src_pending | input | 4 | Pending levels: port 1 PHY, port 2 PHY, switch fabric, timestamp unit (bit 0 first) |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
Sticky bits, the enable word and the master gate change at the clock edge where their cause is presented. The bench drives on a falling edge and reads back on the next falling edge. Level bits 29..26 and all read data are combinational, so they are compared within the same cycle, a nanosecond after the input changes. `irq_o` carries one extra register stage, so each interrupt check waits one further falling edge after the status or enable change. The bench also confirms that the line was still unchanged one cycle before that. The midpoint check holds each counter value for a full cycle so that the previous-value register sees every step.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned B_SWI     = 31;
  localparam int unsigned B_READY   = 30;
  localparam int unsigned LVL_LSB   = 26;
  localparam int unsigned LVL_N     = 4;
  localparam int unsigned B_TXHALT  = 25;
  localparam int unsigned B_RXHALT  = 24;
  localparam int unsigned B_DROPMID = 23;
  localparam int unsigned B_TXIOC   = 21;
  localparam int unsigned B_RXDMA   = 20;
  localparam logic [DATA_W-1:0] STICKY_MASK = 32'hC3B0_0000;
  localparam logic [DATA_W-1:0] LEVEL_MASK  = 32'h3C00_0000;
  localparam logic [DATA_W-1:0] ENABLE_MASK = STICKY_MASK | LEVEL_MASK;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/nic_irq_sticky.sv
module nic_irq_sticky #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q_o[i] <= 1'b0;
        else if (set_i[i]) q_o[i] <= 1'b1;
        else if (clr_i[i]) q_o[i] <= 1'b0;
      end
    end else begin : g_tie
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/nic_irq_midpoint.sv
module nic_irq_midpoint #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cross_o
);
  localparam logic [CNT_W-1:0] BELOW_HALF = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] AT_HALF    = {1'b1, {(CNT_W-1){1'b0}}};
  logic [CNT_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cnt_i;
  end

  assign cross_o = (prev_q == BELOW_HALF) && (cnt_i == AT_HALF);
endmodule

// File: rtl/nic_irq_rise.sv
module nic_irq_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
  import nic_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CNT_W    = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h54,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h58,
  parameter logic [ADDR_W-1:0] ENAB_OFS = 8'h5C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt_tx_halt,
  input  logic              evt_rx_halt,
  input  logic              evt_tx_ioc,
  input  logic              evt_rx_dma,
  input  logic [CNT_W-1:0]  drop_count,
  input  logic              dev_ready,
  input  logic [LVL_N-1:0]  src_pending,
  output logic              irq_o
);
  logic  wr_stat, wr_enab, wr_ctrl;
  logic  drop_mid, ready_rise;
  word_t set_vec, clr_vec, sticky_q, status, enable_q;
  logic  master_q, irq_q;

  assign wr_stat = reg_wr && (reg_addr == STAT_OFS);
  assign wr_enab = reg_wr && (reg_addr == ENAB_OFS);
  assign wr_ctrl = reg_wr && (reg_addr == CTRL_OFS);

  nic_irq_midpoint #(.CNT_W(CNT_W)) u_mid (
    .clk(clk), .rst_n(rst_n), .cnt_i(drop_count), .cross_o(drop_mid)
  );

  nic_irq_rise u_ready (
    .clk(clk), .rst_n(rst_n), .lvl_i(dev_ready), .rise_o(ready_rise)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[B_SWI]     = wr_enab & reg_wdata[B_SWI];
    set_vec[B_READY]   = ready_rise;
    set_vec[B_TXHALT]  = evt_tx_halt;
    set_vec[B_RXHALT]  = evt_rx_halt;
    set_vec[B_DROPMID] = drop_mid;
    set_vec[B_TXIOC]   = evt_tx_ioc;
    set_vec[B_RXDMA]   = evt_rx_dma;
  end

  assign clr_vec = wr_stat ? (reg_wdata & STICKY_MASK) : '0;

  nic_irq_sticky #(.W(DATA_W), .MASK(STICKY_MASK)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .q_o(sticky_q)
  );

  always_comb begin
    status = sticky_q;
    status[LVL_LSB +: LVL_N] = src_pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      master_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_enab) enable_q <= reg_wdata & ENABLE_MASK;
      if (wr_ctrl) master_q <= reg_wdata[0];
      irq_q <= master_q & (|(status & enable_q));
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    unique case (1'b1)
      (reg_addr == STAT_OFS): reg_rdata = status;
      (reg_addr == ENAB_OFS): reg_rdata = enable_q;
      (reg_addr == CTRL_OFS): reg_rdata = {{(DATA_W-1){1'b0}}, master_q};
      default:                reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nic_irq_ctrl_chk.sv
module nic_irq_ctrl_chk
  import nic_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h58
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              evt_tx_halt,
  input logic              evt_rx_halt,
  input logic [CNT_W-1:0]  drop_count,
  input logic [LVL_N-1:0]  src_pending,
  input logic [DATA_W-1:0] sticky_q,
  input logic              master_q,
  input logic              irq_o
);
  localparam logic [CNT_W-1:0] BELOW_HALF = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] AT_HALF    = {1'b1, {(CNT_W-1){1'b0}}};
  logic up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  a_r2_tx_halt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tx_halt |=> sticky_q[B_TXHALT]);

  a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_tx_halt && reg_wr && reg_addr == STAT_OFS && reg_wdata[B_TXHALT]) |=> sticky_q[B_TXHALT]);

  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == STAT_OFS && reg_wdata[B_RXHALT] && !evt_rx_halt) |=> !sticky_q[B_RXHALT]);

  a_r5_level_view: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == STAT_OFS) |-> (reg_rdata[LVL_LSB +: LVL_N] == src_pending));

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == STAT_OFS) |-> (reg_rdata[22] == 1'b0 && reg_rdata[19:0] == 20'h0));

  a_r11_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !master_q |=> !irq_o);

  a_r6_midpoint: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(drop_count) == BELOW_HALF && drop_count == AT_HALF) |=> sticky_q[B_DROPMID]);
endmodule

bind nic_irq_ctrl nic_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .STAT_OFS(STAT_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_tx_halt(evt_tx_halt),
  .evt_rx_halt(evt_rx_halt), .drop_count(drop_count), .src_pending(src_pending),
  .sticky_q(sticky_q), .master_q(master_q), .irq_o(irq_o)
);

// File: tb/nic_irq_ctrl_tb_top.sv
module nic_irq_ctrl_tb_top;
  localparam logic [7:0] A_CTRL = 8'h54, A_STAT = 8'h58, A_ENAB = 8'h5C;
  localparam logic [31:0] STICKY = 32'hC3B0_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic evt_tx_halt = 0, evt_rx_halt = 0, evt_tx_ioc = 0, evt_rx_dma = 0;
  logic [31:0] drop_count = '0;
  logic dev_ready = 1'b0;
  logic [3:0] src_pending = '0;
  logic irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nic_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_tx_halt(evt_tx_halt),
    .evt_rx_halt(evt_rx_halt), .evt_tx_ioc(evt_tx_ioc), .evt_rx_dma(evt_rx_dma),
    .drop_count(drop_count), .dev_ready(dev_ready), .src_pending(src_pending),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic cnt_step(input logic [31:0] v);
    drop_count = v; @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d, exp_st;
    logic [31:0] ev_bit [4];
    ev_bit[0] = 32'h1 << 25; ev_bit[1] = 32'h1 << 24;
    ev_bit[2] = 32'h1 << 21; ev_bit[3] = 32'h1 << 20;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_STAT, d); chk("R1 status", d, 32'h0);
    rd(A_ENAB, d); chk("R1 enable", d, 32'h0);
    rd(A_CTRL, d); chk("R1 master", d, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    // R2 R3 R10: each pulse source, no enables
    for (int k = 0; k < 4; k++) begin
      evt_tx_halt = (k == 0); evt_rx_halt = (k == 1);
      evt_tx_ioc = (k == 2); evt_rx_dma = (k == 3);
      @(negedge clk);
      evt_tx_halt = 0; evt_rx_halt = 0; evt_tx_ioc = 0; evt_rx_dma = 0;
      rd(A_STAT, d); chk("R2 set", d, ev_bit[k]);
      @(negedge clk); @(negedge clk);
      rd(A_STAT, d); chk("R2 hold", d, ev_bit[k]);
      chk("R10 reported with enable 0, no irq", {31'b0, irq_o}, 32'h0);
      wr(A_STAT, ~ev_bit[k]);
      rd(A_STAT, d); chk("R3 zero bits keep", d, ev_bit[k]);
      wr(A_STAT, ev_bit[k]);
      rd(A_STAT, d); chk("R3 w1c clears", d, 32'h0);
    end

    // R4: set and clear same cycle
    evt_tx_halt = 1; evt_rx_dma = 1;
    wr(A_STAT, 32'hFFFF_FFFF);
    evt_tx_halt = 0; evt_rx_dma = 0;
    rd(A_STAT, d); chk("R4 set wins", d, (32'h1 << 25) | (32'h1 << 20));
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R4 cleared later", d, 32'h0);

    // R5 level sweep
    for (int v = 0; v < 16; v++) begin
      src_pending = v[3:0];
      rd(A_STAT, d); chk("R5 level mirror", d, 32'(v) << 26);
    end
    src_pending = 4'h5;
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R5 write ignored", d, 32'h5 << 26);
    src_pending = 4'h0;

    // R6 midpoint
    cnt_step(32'h7FFF_FFFE); cnt_step(32'h7FFF_FFFF);
    rd(A_STAT, d); chk("R6 no set below", d, 32'h0);
    cnt_step(32'h8000_0000);
    rd(A_STAT, d); chk("R6 crossing sets", d, 32'h1 << 23);
    wr(A_STAT, 32'h1 << 23);
    cnt_step(32'h8000_0001); cnt_step(32'hFFFF_FFFF); cnt_step(32'h0);
    cnt_step(32'h8000_0000);
    rd(A_STAT, d); chk("R6 other steps ignored", d, 32'h0);

    // R7 ready rise
    dev_ready = 1; @(negedge clk);
    rd(A_STAT, d); chk("R7 rise sets", d, 32'h1 << 30);
    wr(A_STAT, 32'h1 << 30);
    @(negedge clk);
    rd(A_STAT, d); chk("R7 held high stays clear", d, 32'h0);

    // R8 software trigger, R9 enable mask
    wr(A_ENAB, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R8 swi set", d, 32'h1 << 31);
    rd(A_ENAB, d); chk("R9 enable mask", d, 32'hFFB0_0000);
    wr(A_STAT, 32'h1 << 31);
    rd(A_STAT, d); chk("R8 swi cleared", d, 32'h0);
    wr(A_ENAB, 32'h0);

    // R9 reserved bits with everything pending
    evt_tx_halt = 1; evt_rx_halt = 1; evt_tx_ioc = 1; evt_rx_dma = 1; src_pending = 4'hF;
    @(negedge clk);
    evt_tx_halt = 0; evt_rx_halt = 0; evt_tx_ioc = 0; evt_rx_dma = 0;
    rd(A_STAT, d); chk("R9 reserved zero", d & 32'h004F_FFFF, 32'h0);

    // R11 sweep: one enable bit at a time, master on/off
    exp_st = 32'h3F30_0000;
    rd(A_STAT, d); chk("R11 setup status", d, exp_st);
    for (int m = 0; m < 2; m++) begin
      wr(A_CTRL, 32'(m));
      for (int b = 20; b < 31; b++) begin
        if (b == 22) continue;
        wr(A_ENAB, 32'h1 << b);
        @(negedge clk);
        chk("R11 irq level", {31'b0, irq_o}, 32'(m) & 32'(exp_st[b]));
      end
    end
    // R11: master on, enable all except swi, clear sources
    wr(A_ENAB, 32'h7FB0_0000);
    @(negedge clk);
    chk("R11 irq high", {31'b0, irq_o}, 32'h1);
    src_pending = 4'h0;
    wr(A_STAT, STICKY);
    chk("R11 one cycle late", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    chk("R11 drops after clear", {31'b0, irq_o}, 32'h0);

    // R12 unmapped
    rd(8'h00, d); chk("R12 unmapped", d, 32'h0);
    rd(8'h60, d); chk("R12 unmapped", d, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule